// File: doc/BRIEF.md
# Dual-Modulus Fractional Clock Divider

This block divides an input clock by a ratio that does not have to be a whole number. It counts input clock edges and marks the end of each division cycle with a one-clock pulse. Every division cycle lasts either N or N+1 input clocks. A first-order phase accumulator makes the choice for each cycle. Once per cycle it adds the fractional word K, which is out of 2^W. Its carry selects the longer modulus, so over time the average ratio is exactly N + K/2^W.

A plain accumulator produces a strictly periodic selection pattern. To break that pattern, an optional dither applies a first difference of an LFSR bit to the accumulator input. This scaled term is +2^D, 0 or −2^D in each cycle, and its sum over any run telescopes to a bounded value. The selection sequence changes, but the carry count over a long run does not. The counter loads its modulus only when a cycle ends. N, K and the dither enable are taken at that same edge, so a cycle that is already running is never stretched or shortened.

Top module: `fracn_div`

## Requirements
- R1: While rst_ni is low (asynchronous), pulse_o and sel_o are both 0.
- R2: pulse_o is high for exactly one input clock per division cycle. The cycle length in clocks equals N + sel_o, where sel_o = 1 means N+1 and sel_o = 0 means N. sel_o holds one value for the whole cycle, including its pulse clock. The first cycle starts at the first rising edge after reset is released.
- R3: With K = 0, every cycle lasts N clocks and sel_o stays 0, whether dither is enabled or not.
- R4: With dither off, and N and K held constant from reset, cycle p (counting from p = 1) uses N+1 exactly when floor(p·K/2^W) > floor((p−1)·K/2^W).
- R5: With N, K and the dither setting held constant from reset, the first 2^W cycles contain exactly K cycles at N+1. Their total length is therefore 2^W·N + K clocks, with or without dither.
- R6: Dither is active only when dither_en_i is high and 2^D ≤ K ≤ 2^W − 2^D, where D is DITH_SH. In that case the selection sequence departs from the R4 sequence. Outside that window dither has no effect, and the R4 sequence holds even with dither_en_i high.
- R7: n_i, k_i and dither_en_i are sampled only on the edge that starts a cycle. A change in the middle of a cycle does not alter the length or the selection of that cycle; it applies from the next cycle on.
- R8: The values 0 and 1 on n_i are treated as N = 2.
- R9: The largest N, 2^CNT_W − 1, gives cycles of 2^CNT_W − 1 and 2^CNT_W clocks without wrapping the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| n_i | input | CNT_W | Integer modulus N |
| k_i | input | FRAC_W | Fractional word K, in units of 2^-FRAC_W |
| dither_en_i | input | 1 | Enables the zero-mean LFSR dither |
| pulse_o | output | 1 | One-clock pulse on the last clock of each division cycle |
| sel_o | output | 1 | Modulus of the current cycle: 1 = N+1, 0 = N |

## Verification
The bench first checks that each cycle's measured length matches the selection shown for it. It then counts N+1 cycles over a full 2^W-cycle window, so a design that leaks a fractional count or pairs the wrong carry with a cycle misses K by one. It drives n_i values 0 and 255 to reach the clamp and the largest modulus, where a narrow counter would wrap. It drives K at both ends and outside the dither window, where a design that lets dither act would change the plain sequence or lose exactness. It also changes n_i and k_i in the middle of a cycle, which catches a design that reloads early or adds a carry into the cycle already running.

// File: rtl/fracn_div_pkg.sv
package fracn_div_pkg;

  // maximal-length Galois taps, right-shift form
  function automatic logic [31:0] lfsr_taps(input int unsigned width);
    case (width)
      8:       return 32'h0000_00B8;
      12:      return 32'h0000_0E08;
      16:      return 32'h0000_B400;
      24:      return 32'h00E1_0000;
      32:      return 32'hA300_0000;
      default: return 32'h0000_B400;
    endcase
  endfunction

  function automatic int unsigned min_modulus();
    return 2;
  endfunction

endpackage

// File: rtl/fracn_lfsr.sv
module fracn_lfsr #(
  parameter int unsigned LFSR_W = 16,
  parameter logic [LFSR_W-1:0] SEED = LFSR_W'(16'hACE1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output logic bit_o
);
  import fracn_div_pkg::*;

  localparam logic [LFSR_W-1:0] TAPS = LFSR_W'(lfsr_taps(LFSR_W));

  logic [LFSR_W-1:0] state_q;
  logic [LFSR_W-1:0] state_d;

  always_comb begin
    state_d = state_q >> 1;
    if (state_q[0]) state_d = state_d ^ TAPS;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= SEED;
    else if (step_i) state_q <= state_d;
  end

  assign bit_o = state_q[0];

endmodule

// File: rtl/fracn_mod_ctrl.sv
module fracn_mod_ctrl #(
  parameter int unsigned FRAC_W  = 16,
  parameter int unsigned DITH_SH = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic [FRAC_W-1:0] k_i,
  input  logic              dither_req_i,
  output logic              carry_o,
  output logic              sel_o
);
  localparam int unsigned SUM_W = FRAC_W + 2;
  localparam logic [FRAC_W:0] AMP  = (FRAC_W+1)'(1) << DITH_SH;
  localparam logic [FRAC_W:0] FULL = {1'b1, {FRAC_W{1'b0}}};
  localparam logic [FRAC_W:0] K_HI = FULL - AMP;

  logic [FRAC_W-1:0] acc_q;
  logic              dprev_q;
  logic              sel_q;
  logic              in_win;
  logic              d_now;
  logic [SUM_W-1:0]  add_t;
  logic [SUM_W-1:0]  sub_t;
  logic [SUM_W-1:0]  sum;
  logic              neg;

  // dither window keeps every step non-negative and carry at most one
  assign in_win = ({1'b0, k_i} >= AMP) && ({1'b0, k_i} <= K_HI);
  assign d_now  = dither_req_i & in_win;

  assign add_t = d_now   ? {1'b0, AMP} : '0;
  assign sub_t = dprev_q ? {1'b0, AMP} : '0;
  assign sum   = {2'b00, acc_q} + {2'b00, k_i} + add_t - sub_t;
  assign neg   = sum[SUM_W-1];

  assign carry_o = !neg && sum[FRAC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      dprev_q <= 1'b0;
      sel_q   <= 1'b0;
    end else if (step_i) begin
      acc_q   <= neg ? '0 : sum[FRAC_W-1:0];
      dprev_q <= d_now;
      sel_q   <= carry_o;
    end
  end

  assign sel_o = sel_q;

endmodule

// File: rtl/fracn_cnt.sv
module fracn_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] n_i,
  input  logic             plus_i,
  output logic             load_o,
  output logic             pulse_o
);
  localparam int unsigned MOD_W = CNT_W + 1;

  logic [MOD_W-1:0] cnt_q;

  // cnt_q == 0 only after reset: first edge loads without a pulse
  assign load_o  = (cnt_q <= MOD_W'(1));
  assign pulse_o = (cnt_q == MOD_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_o) cnt_q <= {1'b0, n_i} + MOD_W'(plus_i);
    else             cnt_q <= cnt_q - MOD_W'(1);
  end

endmodule

// File: rtl/fracn_div.sv
module fracn_div #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned FRAC_W  = 16,
  parameter int unsigned DITH_SH = 14,
  parameter int unsigned LFSR_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  n_i,
  input  logic [FRAC_W-1:0] k_i,
  input  logic              dither_en_i,
  output logic              pulse_o,
  output logic              sel_o
);
  import fracn_div_pkg::*;

  localparam logic [CNT_W-1:0] N_MIN = CNT_W'(min_modulus());

  logic             load;
  logic             carry;
  logic             lfsr_bit;
  logic [CNT_W-1:0] n_eff;

  assign n_eff = (n_i < N_MIN) ? N_MIN : n_i;

  fracn_lfsr #(
    .LFSR_W (LFSR_W)
  ) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (load),
    .bit_o  (lfsr_bit)
  );

  fracn_mod_ctrl #(
    .FRAC_W  (FRAC_W),
    .DITH_SH (DITH_SH)
  ) u_mod_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .step_i       (load),
    .k_i          (k_i),
    .dither_req_i (dither_en_i & lfsr_bit),
    .carry_o      (carry),
    .sel_o        (sel_o)
  );

  fracn_cnt #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .n_i     (n_eff),
    .plus_i  (carry),
    .load_o  (load),
    .pulse_o (pulse_o)
  );

endmodule

// File: rtl/fracn_div_chk.sv
module fracn_div_chk #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned FRAC_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CNT_W-1:0]  n_i,
  input logic [FRAC_W-1:0] k_i,
  input logic              load_i,
  input logic              pulse_i,
  input logic              sel_i
);
  localparam int unsigned GAP_W = CNT_W + 2;

  logic [GAP_W-1:0] gap_q;
  logic [CNT_W-1:0] ncap_q;
  logic             started_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q     <= '0;
      ncap_q    <= '0;
      started_q <= 1'b0;
    end else if (load_i) begin
      gap_q     <= GAP_W'(1);
      ncap_q    <= (n_i < CNT_W'(2)) ? CNT_W'(2) : n_i;
      started_q <= 1'b1;
    end else begin
      gap_q <= gap_q + GAP_W'(1);
    end
  end

  // R2
  pulse_one_wide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |=> !pulse_i);

  // R2
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(sel_i));

  // R7
  period_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i && started_q) |-> (gap_q == GAP_W'(ncap_q) + GAP_W'(sel_i)));

  // R3
  zero_frac_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && (k_i == '0)) |=> !sel_i);

endmodule

bind fracn_div fracn_div_chk #(
  .CNT_W  (CNT_W),
  .FRAC_W (FRAC_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .n_i     (n_i),
  .k_i     (k_i),
  .load_i  (load),
  .pulse_i (pulse_o),
  .sel_i   (sel_o)
);

// File: tb/fracn_div_bench.sv
module fracn_div_bench;
  localparam int CNT_W   = 8;
  localparam int FRAC_W  = 8;
  localparam int DITH_SH = 6;
  localparam int NCYC    = 1 << FRAC_W;
  localparam int NV      = 10;
  // columns: n, k, dither, expected clocks over NCYC cycles, mode (0 exact seq, 1 must differ, 2 none)
  localparam int unsigned TBL [NV][5] = '{
    '{4,   0,   0, 1024,  0},
    '{4,   0,   1, 1024,  0},
    '{5,   1,   0, 1281,  0},
    '{3,   128, 0, 896,   0},
    '{3,   64,  1, 832,   1},
    '{6,   160, 1, 1696,  2},
    '{7,   255, 0, 2047,  0},
    '{7,   255, 1, 2047,  0},
    '{0,   64,  0, 576,   0},
    '{255, 2,   0, 65282, 0}
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [CNT_W-1:0]  n_i = '0;
  logic [FRAC_W-1:0] k_i = '0;
  logic              dither_en_i = 1'b0;
  logic              pulse_o;
  logic              sel_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #2 clk_i = ~clk_i;

  fracn_div #(
    .CNT_W   (CNT_W),
    .FRAC_W  (FRAC_W),
    .DITH_SH (DITH_SH),
    .LFSR_W  (16)
  ) u_fracn_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .n_i         (n_i),
    .k_i         (k_i),
    .dither_en_i (dither_en_i),
    .pulse_o     (pulse_o),
    .sel_o       (sel_o)
  );

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: act %0d cycles exp < 190000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic start(input int n, input int k, input bit d);
    @(negedge clk_i);
    rst_ni      = 1'b0;
    n_i         = CNT_W'(n);
    k_i         = FRAC_W'(k);
    dither_en_i = d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wait_pulse(output int len, output bit s);
    len = 0;
    do begin
      @(negedge clk_i);
      len++;
    end while (!pulse_o && len < 400);
    s = sel_o;
  endtask

  initial begin
    int len;
    bit s;
    bit rst_ok;

    // R1: outputs held low during reset
    rst_ok = 1'b1;
    n_i = 8'd3;
    k_i = 8'd200;
    repeat (5) begin
      @(negedge clk_i);
      if (pulse_o || sel_o) rst_ok = 1'b0;
    end
    check(rst_ok, "R1 reset outputs", int'({pulse_o, sel_o}), 0);

    for (int v = 0; v < NV; v++) begin
      int neff;
      int tot;
      int bad_len;
      int bad_sel;
      int diff;
      int kk;
      int seq_exp;
      string tag_len;
      string tag_seq;
      neff    = (TBL[v][0] < 2) ? 2 : int'(TBL[v][0]);
      kk      = int'(TBL[v][1]);
      tot     = 0;
      bad_len = 0;
      bad_sel = 0;
      diff    = 0;
      tag_len = (TBL[v][0] < 2) ? "R8" : ((TBL[v][0] == 255) ? "R9" : "R2");
      tag_seq = (kk == 0) ? "R3" : ((TBL[v][2] != 0) ? "R6" : "R4");
      start(int'(TBL[v][0]), kk, TBL[v][2] != 0);
      for (int p = 1; p <= NCYC; p++) begin
        wait_pulse(len, s);
        tot += len;
        if (len != neff + int'(s)) bad_len++;
        seq_exp = (p * kk) / NCYC - ((p - 1) * kk) / NCYC;
        if (int'(s) != seq_exp) diff++;
      end
      bad_sel = diff;
      check(bad_len == 0, tag_len, bad_len, 0);
      check(tot == int'(TBL[v][3]), "R5 total clocks", tot, int'(TBL[v][3]));
      if (TBL[v][4] == 0) check(bad_sel == 0, tag_seq, bad_sel, 0);
      if (TBL[v][4] == 1) check(diff > 0, "R6 dither alters sequence", diff, 1);
    end

    // R1: asynchronous reset in mid-run
    start(7, 255, 1'b0);
    repeat (20) @(negedge clk_i);
    #1 rst_ni = 1'b0;
    #0.5;
    check(!pulse_o && !sel_o, "R1 async reset", int'({pulse_o, sel_o}), 0);

    // R7: mid-cycle reprogramming waits for the boundary
    start(10, 0, 1'b0);
    wait_pulse(len, s);
    check(len == 10, "R7 first cycle", len, 10);
    repeat (3) @(negedge clk_i);
    n_i = 8'd4;
    k_i = 8'd255;
    wait_pulse(len, s);
    check(len + 3 == 10 && s == 1'b0, "R7 running cycle kept", len + 3, 10);
    wait_pulse(len, s);
    check(len == 4 && s == 1'b0, "R7 new n first cycle", len, 4);
    wait_pulse(len, s);
    check(len == 5 && s == 1'b1, "R7 new k carry", len, 5);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule